// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits next to instruction decode in a processor with hypervisor support. For each class of privileged or context-dependent instruction it reports whether the instruction must trap as an illegal instruction or as a virtual instruction. Decode supplies a class-select vector that says which classes the current instruction belongs to. The block also reads the current privilege level and virtualization bit, the trap-control bits of the machine and hypervisor status registers, the floating-point and vector context states, and the dynamic rounding mode.

The result is two flag vectors, one bit per class. Each vector is registered, so a flag appears one clock after its inputs are presented. At most one of the two flags of a class is ever raised. When both conditions hold, the illegal-instruction flag takes priority.

Privilege is given as a 2-bit level (0 = user, 1 = supervisor, 3 = machine) plus the virtualization bit. Level 0 with the bit clear is host user (HU). Level 1 with the bit clear is host supervisor (HS). Level 1 with the bit set is virtual supervisor (VS). Level 0 with the bit set is virtual user (VU). In machine mode the virtualization bit is ignored.

Top module: `priv_legality_chk`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, both flag vectors are zero. Every flag reflects the inputs sampled at the previous rising clock edge, so the latency is one cycle.
- R2: Flag bit positions are 0 = address-translation fence (sfence.vma/sinval.vma), 1 = partial fence (sfence.w.inval/sfence.inval.ir), 2 = guest-physical hypervisor fence, 3 = guest-virtual hypervisor fence, 4 = hypervisor load/store, 5 = floating point, 6 = vector, 7 = wait-for-interrupt, 8 = rounding-mode check. A class whose `cls_sel` bit is 0 raises neither flag.
- R3: The illegal flag of classes 0 and 2 is raised in HS mode when `tvm`=1, and in HU mode.
- R4: The illegal flag of classes 1 and 3 is raised only in HU mode.
- R5: The illegal flag of class 4 is raised in HU mode when `hu_en`=0.
- R6: The illegal flag of class 5 is raised when `fs_state`=0. The illegal flag of class 6 is raised when `vs_state`=0.
- R7: The illegal flag of class 7 is raised in HU mode, and in any mode other than machine mode when `tw`=1.
- R8: The illegal flag of class 8 is raised when `rnd_mode` is greater than 4.
- R9: The virtual flag of class 0 is raised in VS mode when `vtvm`=1, and in VU mode. The virtual flag of class 1 is raised only in VU mode.
- R10: The virtual flags of classes 2, 3 and 4 are raised in VS and VU mode.
- R11: The virtual flag of class 7 is raised in VU mode when `tw`=0, and in VS mode when `tw`=0 and `vtw`=1. Classes 5, 6 and 8 never raise a virtual flag.
- R12: In machine mode no virtual flag is raised, whatever `virt` is. No class ever has both flags set; when both conditions hold, only the illegal flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_sel | input | 9 | Instruction class select, one bit per class |
| priv_lvl | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine |
| virt | input | 1 | Virtualization bit |
| tvm | input | 1 | Machine trap-virtual-memory control |
| tw | input | 1 | Machine timeout-wait control |
| vtvm | input | 1 | Hypervisor trap-virtual-memory control for guests |
| vtw | input | 1 | Hypervisor timeout-wait control for guests |
| hu_en | input | 1 | Hypervisor-in-user enable |
| fs_state | input | 2 | Floating-point context state, 0 = off |
| vs_state | input | 2 | Vector context state, 0 = off |
| rnd_mode | input | RM_W (3) | Dynamic rounding mode |
| ill_flags | output | 9 | Registered illegal-instruction flags |
| vir_flags | output | 9 | Registered virtual-instruction flags |

## Verification
The assertions assume that `priv_lvl` never takes the reserved value 2. Under that value no mode is decoded, and the implications about guest modes would not apply. They also assume that inputs change only between clock edges. The bench drives every input just after a rising edge, picks privilege levels only from {0, 1, 3}, and sweeps every combination of the five control bits with the virtualization bit across those three levels.

// File: rtl/privchk_pkg.sv
package privchk_pkg;
  localparam int NUM_CLS   = 9;
  localparam int CLS_SFVMA = 0;
  localparam int CLS_SFPRT = 1;
  localparam int CLS_HFGV  = 2;
  localparam int CLS_HFVV  = 3;
  localparam int CLS_HLDST = 4;
  localparam int CLS_FP    = 5;
  localparam int CLS_VEC   = 6;
  localparam int CLS_WFI   = 7;
  localparam int CLS_RM    = 8;

  localparam logic [1:0] LVL_U = 2'd0;
  localparam logic [1:0] LVL_S = 2'd1;
  localparam logic [1:0] LVL_M = 2'd3;
  localparam logic [1:0] CTX_OFF = 2'd0;

  typedef struct packed {
    logic hs;
    logic vs;
    logic hu;
    logic vu;
  } mode_t;
endpackage

// File: rtl/privchk_mode_dec.sv
module privchk_mode_dec
  import privchk_pkg::*;
(
  input  logic [1:0] lvl,
  input  logic       virt,
  output mode_t      mode
);
  always_comb begin
    mode    = '0;
    mode.hs = (lvl == LVL_S) && !virt;
    mode.vs = (lvl == LVL_S) &&  virt;
    mode.hu = (lvl == LVL_U) && !virt;
    mode.vu = (lvl == LVL_U) &&  virt;
  end
endmodule

// File: rtl/privchk_ill_rules.sv
module privchk_ill_rules
  import privchk_pkg::*;
#(
  parameter int RM_W   = 3,
  parameter int RM_MAX = 4
) (
  input  logic               in_hs,
  input  logic               in_vs,
  input  logic               in_hu,
  input  logic               in_vu,
  input  logic               tvm,
  input  logic               tw,
  input  logic               hu_en,
  input  logic [1:0]         fs_state,
  input  logic [1:0]         vs_state,
  input  logic [RM_W-1:0]    rnd_mode,
  output logic [NUM_CLS-1:0] ill_raw
);
  localparam logic [RM_W-1:0] RM_LIMIT = RM_W'(RM_MAX);

  logic below_m;
  logic tvm_trap;

  always_comb begin
    below_m  = in_hs | in_vs | in_hu | in_vu;
    tvm_trap = (in_hs & tvm) | in_hu;
    ill_raw            = '0;
    ill_raw[CLS_SFVMA] = tvm_trap;
    ill_raw[CLS_SFPRT] = in_hu;
    ill_raw[CLS_HFGV]  = tvm_trap;
    ill_raw[CLS_HFVV]  = in_hu;
    ill_raw[CLS_HLDST] = in_hu & ~hu_en;
    ill_raw[CLS_FP]    = (fs_state == CTX_OFF);
    ill_raw[CLS_VEC]   = (vs_state == CTX_OFF);
    ill_raw[CLS_WFI]   = in_hu | (below_m & tw);
    ill_raw[CLS_RM]    = (rnd_mode > RM_LIMIT);
  end
endmodule

// File: rtl/privchk_vir_rules.sv
module privchk_vir_rules
  import privchk_pkg::*;
(
  input  logic               in_vs,
  input  logic               in_vu,
  input  logic               tw,
  input  logic               vtvm,
  input  logic               vtw,
  output logic [NUM_CLS-1:0] vir_raw
);
  logic guest;

  always_comb begin
    guest              = in_vs | in_vu;
    vir_raw            = '0;
    vir_raw[CLS_SFVMA] = (in_vs & vtvm) | in_vu;
    vir_raw[CLS_SFPRT] = in_vu;
    vir_raw[CLS_HFGV]  = guest;
    vir_raw[CLS_HFVV]  = guest;
    vir_raw[CLS_HLDST] = guest;
    vir_raw[CLS_WFI]   = ~tw & (in_vu | (in_vs & vtw));
  end
endmodule

// File: rtl/privchk_out_stage.sv
module privchk_out_stage
  import privchk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CLS-1:0] sel,
  input  logic [NUM_CLS-1:0] ill_raw,
  input  logic [NUM_CLS-1:0] vir_raw,
  output logic [NUM_CLS-1:0] ill_q,
  output logic [NUM_CLS-1:0] vir_q
);
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    always_ff @(posedge clk) begin
      if (rst) begin
        ill_q[c] <= 1'b0;
        vir_q[c] <= 1'b0;
      end else begin
        ill_q[c] <= sel[c] & ill_raw[c];
        vir_q[c] <= sel[c] & vir_raw[c] & ~ill_raw[c];
      end
    end
  end
endmodule

// File: rtl/priv_legality_chk.sv
module priv_legality_chk
  import privchk_pkg::*;
#(
  parameter int RM_W   = 3,
  parameter int RM_MAX = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CLS-1:0] cls_sel,
  input  logic [1:0]         priv_lvl,
  input  logic               virt,
  input  logic               tvm,
  input  logic               tw,
  input  logic               vtvm,
  input  logic               vtw,
  input  logic               hu_en,
  input  logic [1:0]         fs_state,
  input  logic [1:0]         vs_state,
  input  logic [RM_W-1:0]    rnd_mode,
  output logic [NUM_CLS-1:0] ill_flags,
  output logic [NUM_CLS-1:0] vir_flags
);
  mode_t              mode;
  logic [NUM_CLS-1:0] ill_raw;
  logic [NUM_CLS-1:0] vir_raw;

  privchk_mode_dec u_mode (
    .lvl  (priv_lvl),
    .virt (virt),
    .mode (mode)
  );

  privchk_ill_rules #(.RM_W(RM_W), .RM_MAX(RM_MAX)) u_ill (
    .in_hs    (mode.hs),
    .in_vs    (mode.vs),
    .in_hu    (mode.hu),
    .in_vu    (mode.vu),
    .tvm      (tvm),
    .tw       (tw),
    .hu_en    (hu_en),
    .fs_state (fs_state),
    .vs_state (vs_state),
    .rnd_mode (rnd_mode),
    .ill_raw  (ill_raw)
  );

  privchk_vir_rules u_vir (
    .in_vs   (mode.vs),
    .in_vu   (mode.vu),
    .tw      (tw),
    .vtvm    (vtvm),
    .vtw     (vtw),
    .vir_raw (vir_raw)
  );

  privchk_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .sel     (cls_sel),
    .ill_raw (ill_raw),
    .vir_raw (vir_raw),
    .ill_q   (ill_flags),
    .vir_q   (vir_flags)
  );
endmodule

// File: rtl/privchk_chk.sv
module privchk_chk
  import privchk_pkg::*;
#(
  parameter int RM_W   = 3,
  parameter int RM_MAX = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CLS-1:0] cls_sel,
  input logic [1:0]         priv_lvl,
  input logic               virt,
  input logic               tvm,
  input logic               tw,
  input logic               hu_en,
  input logic [1:0]         fs_state,
  input logic [RM_W-1:0]    rnd_mode,
  input logic [NUM_CLS-1:0] ill_flags,
  input logic [NUM_CLS-1:0] vir_flags
);
  AST_NO_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cls_sel == '0) |=> (ill_flags == '0 && vir_flags == '0)); // R2
  AST_SFVMA_TVM: assert property (@(posedge clk) disable iff (rst)
    (cls_sel[CLS_SFVMA] && priv_lvl == LVL_S && !virt && tvm) |=> ill_flags[CLS_SFVMA]); // R3
  AST_SFPRT_HU: assert property (@(posedge clk) disable iff (rst)
    (cls_sel[CLS_SFPRT] && priv_lvl == LVL_U && !virt) |=> ill_flags[CLS_SFPRT]); // R4
  AST_HLDST_HU: assert property (@(posedge clk) disable iff (rst)
    (cls_sel[CLS_HLDST] && priv_lvl == LVL_U && !virt && !hu_en) |=> ill_flags[CLS_HLDST]); // R5
  AST_FP_OFF: assert property (@(posedge clk) disable iff (rst)
    (cls_sel[CLS_FP] && fs_state == CTX_OFF) |=> ill_flags[CLS_FP]); // R6
  AST_WFI_TW: assert property (@(posedge clk) disable iff (rst)
    (cls_sel[CLS_WFI] && priv_lvl != LVL_M && tw) |=> ill_flags[CLS_WFI]); // R7
  AST_RM_RSVD: assert property (@(posedge clk) disable iff (rst)
    (cls_sel[CLS_RM] && rnd_mode > RM_W'(RM_MAX)) |=> ill_flags[CLS_RM]); // R8
  AST_SFPRT_VU: assert property (@(posedge clk) disable iff (rst)
    (cls_sel[CLS_SFPRT] && priv_lvl == LVL_U && virt) |=> vir_flags[CLS_SFPRT]); // R9
  AST_HLDST_GUEST: assert property (@(posedge clk) disable iff (rst)
    (cls_sel[CLS_HLDST] && virt && (priv_lvl == LVL_U || priv_lvl == LVL_S)) |=> vir_flags[CLS_HLDST]); // R10
  AST_WFI_VU: assert property (@(posedge clk) disable iff (rst)
    (cls_sel[CLS_WFI] && priv_lvl == LVL_U && virt && !tw) |=> vir_flags[CLS_WFI]); // R11
  AST_M_NO_VIR: assert property (@(posedge clk) disable iff (rst)
    (priv_lvl == LVL_M) |=> (vir_flags == '0)); // R12
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    ((ill_flags & vir_flags) == '0)); // R12
endmodule

bind priv_legality_chk privchk_chk #(.RM_W(RM_W), .RM_MAX(RM_MAX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cls_sel   (cls_sel),
  .priv_lvl  (priv_lvl),
  .virt      (virt),
  .tvm       (tvm),
  .tw        (tw),
  .hu_en     (hu_en),
  .fs_state  (fs_state),
  .rnd_mode  (rnd_mode),
  .ill_flags (ill_flags),
  .vir_flags (vir_flags)
);

// File: tb/priv_legality_chk_bench.sv
module priv_legality_chk_bench;
  localparam int NC = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] cls_sel = '0;
  logic [1:0]    priv_lvl = 2'd3;
  logic          virt = 1'b0;
  logic          tvm = 1'b0;
  logic          tw = 1'b0;
  logic          vtvm = 1'b0;
  logic          vtw = 1'b0;
  logic          hu_en = 1'b0;
  logic [1:0]    fs_state = 2'd1;
  logic [1:0]    vs_state = 2'd1;
  logic [2:0]    rnd_mode = 3'd0;
  logic [NC-1:0] ill_flags;
  logic [NC-1:0] vir_flags;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  priv_legality_chk u_priv_legality_chk (
    .clk(clk), .rst(rst), .cls_sel(cls_sel), .priv_lvl(priv_lvl), .virt(virt),
    .tvm(tvm), .tw(tw), .vtvm(vtvm), .vtw(vtw), .hu_en(hu_en),
    .fs_state(fs_state), .vs_state(vs_state), .rnd_mode(rnd_mode),
    .ill_flags(ill_flags), .vir_flags(vir_flags)
  );

  // Expected flags derived from the requirements: {vir, ill}
  function automatic logic [2*NC-1:0] model();
    logic hs, vs, hu, vu, below_m;
    logic [NC-1:0] il, vi;
    hs = (priv_lvl == 2'd1) && !virt;
    vs = (priv_lvl == 2'd1) && virt;
    hu = (priv_lvl == 2'd0) && !virt;
    vu = (priv_lvl == 2'd0) && virt;
    below_m = (priv_lvl != 2'd3);
    il = '0;
    vi = '0;
    il[0] = (hs && tvm) || hu;
    il[1] = hu;
    il[2] = (hs && tvm) || hu;
    il[3] = hu;
    il[4] = hu && !hu_en;
    il[5] = (fs_state == 2'd0);
    il[6] = (vs_state == 2'd0);
    il[7] = hu || (below_m && tw);
    il[8] = (rnd_mode > 3'd4);
    vi[0] = (vs && vtvm) || vu;
    vi[1] = vu;
    vi[2] = vs || vu;
    vi[3] = vs || vu;
    vi[4] = vs || vu;
    vi[7] = (vu && !tw) || (vs && !tw && vtw);
    il = il & cls_sel;
    vi = vi & cls_sel & ~il;
    return {vi, il};
  endfunction

  task automatic check(input string req, input logic [NC-1:0] exp_ill, input logic [NC-1:0] exp_vir);
    n_checks++;
    if (ill_flags !== exp_ill || vir_flags !== exp_vir) begin
      n_fail++;
      $display("FAIL %s: ill=%b vir=%b expected ill=%b vir=%b", req, ill_flags, vir_flags, exp_ill, exp_vir);
    end
  endtask

  // Drive after the edge, let one edge capture, sample 1 ns later
  task automatic step_and_check(input string req);
    logic [2*NC-1:0] e;
    e = model();
    @(posedge clk);
    #1;
    check(req, e[NC-1:0], e[2*NC-1:NC]);
  endtask

  task automatic set_ctl(input logic [1:0] l, input logic v, input logic a_tvm, input logic a_tw,
                         input logic a_vtvm, input logic a_vtw, input logic a_hu);
    priv_lvl = l; virt = v; tvm = a_tvm; tw = a_tw; vtvm = a_vtvm; vtw = a_vtw; hu_en = a_hu;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cls_sel = '1; priv_lvl = 2'd0; virt = 1'b0; fs_state = 2'd0; vs_state = 2'd0; rnd_mode = 3'd7;
    @(posedge clk); #1;
    check("R1 during reset", '0, '0);
    @(posedge clk); #1;
    check("R1 during reset", '0, '0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 first cycle after reset", 9'h1FF, '0);
  endtask

  task automatic t_no_select();
    cls_sel = '0; set_ctl(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    fs_state = 2'd0; vs_state = 2'd0; rnd_mode = 3'd6;
    @(posedge clk); #1;
    check("R2 nothing selected", '0, '0);
    cls_sel = 9'b0_0000_0010; set_ctl(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R2 only partial fence selected", '0, 9'b0_0000_0010);
  endtask

  task automatic t_fences();
    fs_state = 2'd1; vs_state = 2'd1; rnd_mode = 3'd0; cls_sel = 9'b0_0000_1111;
    set_ctl(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R3 HS tvm=1", 9'b0_0000_0101, '0);
    set_ctl(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R3 HS tvm=0", '0, '0);
    set_ctl(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R4 HU all fences", 9'b0_0000_1111, '0);
    set_ctl(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R9 VS vtvm=1", '0, 9'b0_0000_1101);
    set_ctl(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R10 VS hfences", '0, 9'b0_0000_1100);
    set_ctl(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R9 VU all fences", '0, 9'b0_0000_1111);
  endtask

  task automatic t_hyp_ldst();
    cls_sel = 9'b0_0001_0000;
    set_ctl(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R5 HU hu_en=0", 9'b0_0001_0000, '0);
    hu_en = 1'b1;
    @(posedge clk); #1;
    check("R5 HU hu_en=1", '0, '0);
    set_ctl(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1;
    check("R10 VU hyp ld/st", '0, 9'b0_0001_0000);
  endtask

  task automatic t_context();
    cls_sel = 9'b1_0110_0000; set_ctl(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    fs_state = 2'd0; vs_state = 2'd3; rnd_mode = 3'd4;
    @(posedge clk); #1;
    check("R6 fs off", 9'b0_0010_0000, '0);
    fs_state = 2'd2; vs_state = 2'd0; rnd_mode = 3'd5;
    @(posedge clk); #1;
    check("R6 R8 vs off, rm=5", 9'b1_0100_0000, '0);
    fs_state = 2'd1; vs_state = 2'd1; rnd_mode = 3'd7; virt = 1'b1;
    @(posedge clk); #1;
    check("R8 rm=7", 9'b1_0000_0000, '0);
  endtask

  task automatic t_wfi();
    fs_state = 2'd1; vs_state = 2'd1; rnd_mode = 3'd0; cls_sel = 9'b0_1000_0000;
    set_ctl(2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R12 M mode with virt=1, tw=1", '0, '0);
    set_ctl(2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R7 HS tw=1", 9'b0_1000_0000, '0);
    set_ctl(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R11 VS tw=0 vtw=1", '0, 9'b0_1000_0000);
    set_ctl(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R12 VS tw=1 vtw=1 illegal wins", 9'b0_1000_0000, '0);
    set_ctl(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R11 VU tw=0", '0, 9'b0_1000_0000);
  endtask

  task automatic t_sweep();
    cls_sel = '1;
    for (int li = 0; li < 3; li++) begin
      for (int b = 0; b < 64; b++) begin
        set_ctl((li == 0) ? 2'd0 : (li == 1) ? 2'd1 : 2'd3, b[0], b[1], b[2], b[3], b[4], b[5]);
        fs_state = 2'(b % 3);
        vs_state = 2'((b + 1) % 3);
        rnd_mode = 3'(b % 8);
        step_and_check("R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 sweep");
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_no_select();
    t_fences();
    t_hyp_ldst();
    t_context();
    t_wfi();
    t_sweep();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule